// File: doc/BRIEF.md
# Serial Block-Write Control Register Slave

This block is a two-wire serial slave that holds a small bank of control bytes, such as output enables and frequency or mode selectors, and presents all of them at once as a flat parallel bus. After reset every byte holds a parameter-given default, so the surrounding logic works even if nothing is ever programmed.

Writes use a block format: the device address with the write bit, then a command byte, then a byte count, then data bytes. Data always lands in register 0 first and then in the registers above it, so a host that wants to change one byte must also send every byte below it. A read with the read bit returns the stored bytes from register 0 upward until the host answers with a not-acknowledge. Both lines pass through a synchronizer and a glitch filter clocked by the system clock before any START, STOP or bit sampling is decided. The SDA output is an open-drain pull-down request.

Top module: `ctlreg_i2c_slave`

## Requirements
- R1: After reset the parallel bus equals the default bytes (register i on bits [8i+7:8i]) and the slave does not pull SDA low.
- R2: An address byte of 1101_0010 (7-bit address 1101001, write bit 0) is acknowledged by pulling SDA low during the ninth clock; any other address is not acknowledged, and the slave drives nothing until the next START.
- R3: The byte after the address must be 0000_0000; any other value is not acknowledged, and no following byte is acknowledged or stored until the next START.
- R4: The byte after the command is a count; a value from 1 to the register count is acknowledged, while 0 or a larger value is not acknowledged and ends the transfer.
- R5: Data bytes arrive most significant bit first, are stored in registers 0, 1, 2 and so on in order, and each stored byte is acknowledged.
- R6: A data byte beyond the count, or beyond the last register, is not acknowledged and changes no register.
- R7: A START in the middle of a transfer abandons it and begins a new address byte.
- R8: A STOP returns the slave to idle with SDA released; bytes clocked afterwards without a START are neither acknowledged nor stored.
- R9: An address byte of 1101_0011 is acknowledged and the slave then sends register 0, 1, and upward, most significant bit first, wrapping from the last register to register 0, while the host acknowledges; after a host not-acknowledge it releases SDA.
- R10: A pulse on SCL shorter than the filter length is ignored and adds no bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_drive_low_o | output | 1 | When 1, the slave pulls SDA low (open drain) |
| ctrl_regs_o | output | NUM_REGS*8 | Register bank, register i on bits [8i+7:8i] |

## Verification
The two functions that can meet in one moment are a START condition and an open transfer whose byte bookkeeping is still live: a data byte has just been acknowledged, the pointer has advanced and a count is held, when the host issues a repeated START. The bench provokes this by writing part of a block, then restarting straight into a read address; it judges the outcome by the acknowledge of the new address and by the first returned byte being register 0 with the partly written value. A second overlap, a filter glitch on SCL during a data bit, is judged by the stored byte matching the intended one.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_CMD,
      PH_CNT,
      PH_WDATA,
      PH_RDATA
   } i2cw_phase_e;

   function automatic int idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/i2cw_line_filter.sv
module i2cw_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int FILT_LEN    = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("i2cw_line_filter: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("i2cw_line_filter: FILT_LEN must be at least 1");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic [FILT_LEN-1:0]    hist_q;
   logic                   q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
   end

   if (FILT_LEN == 1) begin : g_hist_one
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist_q <= '1;
         else        hist_q <= sync_q[SYNC_STAGES-1];
      end
   end else begin : g_hist_many
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hist_q <= '1;
         else        hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_STAGES-1]};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         q <= 1'b1;
      else if (&hist_q)   q <= 1'b1;
      else if (~|hist_q)  q <= 1'b0;
   end

   assign line_o = q;

   assert_rise_after_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(q) |-> $past(&hist_q));
   assert_fall_after_agree_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(q) |-> $past(~|hist_q));

endmodule

// File: rtl/i2cw_regbank.sv
module i2cw_regbank #(
   parameter int                      NUM_REGS     = 4,
   parameter logic [NUM_REGS*8-1:0]   REG_DEFAULTS = '0,
   localparam int                     IW           = i2cw_pkg::idx_w(NUM_REGS)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  we_i,
   input  logic [IW-1:0]         widx_i,
   input  logic [7:0]            wdata_i,
   input  logic [IW-1:0]         ridx_i,
   output logic [7:0]            rdata_o,
   output logic [NUM_REGS*8-1:0] bank_o
);

   logic [7:0] bank_q [NUM_REGS];

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              bank_q[g] <= REG_DEFAULTS[8*g +: 8];
         else if (we_i && (widx_i == IW'(g)))     bank_q[g] <= wdata_i;
      end
      assign bank_o[8*g +: 8] = bank_q[g];
   end

   always_comb begin
      rdata_o = '0;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (ridx_i == IW'(i)) rdata_o = bank_q[i];
      end
   end

   assert_bank_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(bank_o));
   assert_widx_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |-> (int'(widx_i) < NUM_REGS));

endmodule

// File: rtl/i2cw_proto.sv
module i2cw_proto import i2cw_pkg::*; #(
   parameter int          NUM_REGS = 4,
   parameter logic [6:0]  DEV_ADDR = 7'b1101001,
   parameter logic [7:0]  CMD_CODE = 8'h00,
   localparam int         IW       = i2cw_pkg::idx_w(NUM_REGS),
   localparam int         PW       = $clog2(NUM_REGS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_f,
   input  logic          sda_f,
   input  logic [7:0]    rdata_i,
   output logic          we_o,
   output logic [IW-1:0] widx_o,
   output logic [7:0]    wdata_o,
   output logic [IW-1:0] ridx_o,
   output logic          sda_oe_o
);

   logic          scl_q, sda_q;
   logic          scl_rise, scl_fall, start_c, stop_c;
   i2cw_phase_e   phase_q;
   logic [3:0]    bitcnt_q;
   logic [7:0]    shreg_q, tx_q, cnt_q;
   logic          ack_q, mack_q, oe_q;
   logic [PW-1:0] ptr_q;
   logic          we_q;
   logic [IW-1:0] widx_q;
   logic [7:0]    wdata_q;
   logic          cnt_ok, room_ok, ptr_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_q;
   assign scl_fall = ~scl_f & scl_q;
   assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
   assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;

   assign cnt_ok   = (shreg_q != 8'd0) && ({1'b0, shreg_q} <= 9'(NUM_REGS));
   assign room_ok  = 9'(ptr_q) < {1'b0, cnt_q};
   assign ptr_last = (ptr_q == PW'(NUM_REGS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         bitcnt_q <= '0;
         shreg_q  <= '0;
         tx_q     <= '0;
         cnt_q    <= '0;
         ack_q    <= 1'b0;
         mack_q   <= 1'b0;
         oe_q     <= 1'b0;
         ptr_q    <= '0;
         we_q     <= 1'b0;
         widx_q   <= '0;
         wdata_q  <= '0;
      end else begin
         we_q <= 1'b0;
         if (start_c) begin
            phase_q  <= PH_ADDR;
            bitcnt_q <= '0;
            ack_q    <= 1'b0;
            mack_q   <= 1'b0;
            oe_q     <= 1'b0;
         end else if (stop_c) begin
            phase_q <= PH_IDLE;
            ack_q   <= 1'b0;
            mack_q  <= 1'b0;
            oe_q    <= 1'b0;
         end else if (phase_q != PH_IDLE) begin
            if (scl_rise) begin
               if (mack_q) begin
                  if (sda_f) begin
                     phase_q <= PH_IDLE;
                     mack_q  <= 1'b0;
                  end
               end else if (!ack_q && phase_q != PH_RDATA) begin
                  shreg_q  <= {shreg_q[6:0], sda_f};
                  bitcnt_q <= bitcnt_q + 4'd1;
               end
            end else if (scl_fall) begin
               if (ack_q || mack_q) begin
                  ack_q  <= 1'b0;
                  mack_q <= 1'b0;
                  if (phase_q == PH_RDATA) begin
                     oe_q     <= ~rdata_i[7];
                     tx_q     <= {rdata_i[6:0], 1'b0};
                     bitcnt_q <= 4'd1;
                  end else begin
                     oe_q     <= 1'b0;
                     bitcnt_q <= '0;
                  end
               end else if (phase_q == PH_RDATA) begin
                  if (bitcnt_q == 4'd8) begin
                     oe_q   <= 1'b0;
                     mack_q <= 1'b1;
                     ptr_q  <= ptr_last ? '0 : ptr_q + 1'b1;
                  end else begin
                     oe_q     <= ~tx_q[7];
                     tx_q     <= {tx_q[6:0], 1'b0};
                     bitcnt_q <= bitcnt_q + 4'd1;
                  end
               end else if (bitcnt_q == 4'd8) begin
                  unique case (phase_q)
                     PH_ADDR: begin
                        if (shreg_q[7:1] == DEV_ADDR) begin
                           ack_q   <= 1'b1;
                           oe_q    <= 1'b1;
                           ptr_q   <= '0;
                           phase_q <= shreg_q[0] ? PH_RDATA : PH_CMD;
                        end else begin
                           phase_q <= PH_IDLE;
                        end
                     end
                     PH_CMD: begin
                        if (shreg_q == CMD_CODE) begin
                           ack_q   <= 1'b1;
                           oe_q    <= 1'b1;
                           phase_q <= PH_CNT;
                        end else begin
                           phase_q <= PH_IDLE;
                        end
                     end
                     PH_CNT: begin
                        if (cnt_ok) begin
                           ack_q   <= 1'b1;
                           oe_q    <= 1'b1;
                           cnt_q   <= shreg_q;
                           phase_q <= PH_WDATA;
                        end else begin
                           phase_q <= PH_IDLE;
                        end
                     end
                     PH_WDATA: begin
                        if (room_ok) begin
                           ack_q   <= 1'b1;
                           oe_q    <= 1'b1;
                           we_q    <= 1'b1;
                           widx_q  <= ptr_q[IW-1:0];
                           wdata_q <= shreg_q;
                           ptr_q   <= ptr_q + 1'b1;
                        end else begin
                           phase_q <= PH_IDLE;
                        end
                     end
                     default: phase_q <= PH_IDLE;
                  endcase
               end
            end
         end
      end
   end

   assign we_o     = we_q;
   assign widx_o   = widx_q;
   assign wdata_o  = wdata_q;
   assign ridx_o   = ptr_q[IW-1:0];
   assign sda_oe_o = oe_q;

   assert_drive_while_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(oe_q) |-> !scl_f);
   assert_idle_released_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_IDLE) |-> !oe_q);
   assert_write_from_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
      we_q |-> $past(phase_q == PH_WDATA));
   assert_bitcnt_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bitcnt_q <= 4'd8);
   assert_start_restarts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      start_c |=> (phase_q == PH_ADDR) && !oe_q);

endmodule

// File: rtl/ctlreg_i2c_slave.sv
module ctlreg_i2c_slave #(
   parameter int                    NUM_REGS     = 4,
   parameter logic [6:0]            DEV_ADDR     = 7'b1101001,
   parameter logic [7:0]            CMD_CODE     = 8'h00,
   parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 32'hC30F_FF81,
   parameter int                    SYNC_STAGES  = 2,
   parameter int                    FILT_LEN     = 3
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_drive_low_o,
   output logic [NUM_REGS*8-1:0] ctrl_regs_o
);

   localparam int IW = i2cw_pkg::idx_w(NUM_REGS);

   if (NUM_REGS < 1 || NUM_REGS > 255) begin : g_bad_regs
      $error("ctlreg_i2c_slave: NUM_REGS must lie in 1..255");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("ctlreg_i2c_slave: SYNC_STAGES must be at least 2");
   end
   if (FILT_LEN < 1) begin : g_bad_filt
      $error("ctlreg_i2c_slave: FILT_LEN must be at least 1");
   end

   logic [1:0]    raw_lines, clean_lines;
   logic          we;
   logic [IW-1:0] widx, ridx;
   logic [7:0]    wdata, rdata;

   assign raw_lines = {sda_i, scl_i};

   for (genvar l = 0; l < 2; l++) begin : g_line
      i2cw_line_filter #(
         .SYNC_STAGES (SYNC_STAGES),
         .FILT_LEN    (FILT_LEN)
      ) u_filt (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw_lines[l]),
         .line_o (clean_lines[l])
      );
   end

   i2cw_proto #(
      .NUM_REGS (NUM_REGS),
      .DEV_ADDR (DEV_ADDR),
      .CMD_CODE (CMD_CODE)
   ) u_proto (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_f    (clean_lines[0]),
      .sda_f    (clean_lines[1]),
      .rdata_i  (rdata),
      .we_o     (we),
      .widx_o   (widx),
      .wdata_o  (wdata),
      .ridx_o   (ridx),
      .sda_oe_o (sda_drive_low_o)
   );

   i2cw_regbank #(
      .NUM_REGS     (NUM_REGS),
      .REG_DEFAULTS (REG_DEFAULTS)
   ) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (we),
      .widx_i  (widx),
      .wdata_i (wdata),
      .ridx_i  (ridx),
      .rdata_o (rdata),
      .bank_o  (ctrl_regs_o)
   );

endmodule

// File: tb/ctlreg_i2c_slave_tb.sv
module ctlreg_i2c_slave_tb;

   localparam logic [31:0] DEF = 32'hC30F_FF81;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        m_scl = 1'b1;
   logic        m_sda_low = 1'b0;
   logic        sda_oe;
   logic        sda_bus;
   logic [31:0] regs;
   logic [7:0]  exp_r [4];
   int          checks = 0;
   int          errors = 0;

   assign sda_bus = ~(m_sda_low | sda_oe);

   always #4 clk = ~clk;

   ctlreg_i2c_slave u_dut (
      .clk             (clk),
      .rst_n           (rst_n),
      .scl_i           (m_scl),
      .sda_i           (sda_bus),
      .sda_drive_low_o (sda_oe),
      .ctrl_regs_o     (regs)
   );

   task automatic w(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, expv);
      end
   endtask

   task automatic chk_regs(input string req);
      for (int i = 0; i < 4; i++)
         chk(regs[8*i +: 8] == exp_r[i], req, {24'd0, regs[8*i +: 8]}, {24'd0, exp_r[i]});
   endtask

   task automatic i2c_start();
      if (!m_scl) begin
         w(10); m_sda_low = 1'b0;
         w(10); m_scl = 1'b1;
         w(20);
      end
      m_sda_low = 1'b1;
      w(20); m_scl = 1'b0;
   endtask

   task automatic i2c_stop();
      w(10); m_sda_low = 1'b1;
      w(10); m_scl = 1'b1;
      w(20); m_sda_low = 1'b0;
      w(20);
   endtask

   task automatic wr_byte(input logic [7:0] b, input bit glitch, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         w(10); m_sda_low = ~b[i];
         if (glitch && i == 3) begin
            w(2); m_scl = 1'b1;
            w(1); m_scl = 1'b0;
            w(7);
         end else begin
            w(10);
         end
         m_scl = 1'b1;
         w(20); m_scl = 1'b0;
      end
      w(10); m_sda_low = 1'b0;
      w(10); m_scl = 1'b1;
      w(10); ack = ~sda_bus;
      w(10); m_scl = 1'b0;
   endtask

   task automatic wbc(input logic [7:0] b, input bit exp_ack, input string req);
      bit a;
      wr_byte(b, 1'b0, a);
      chk(a == exp_ack, req, {31'd0, a}, {31'd0, exp_ack});
   endtask

   task automatic rd_byte(input bit mack, output logic [7:0] b);
      for (int i = 7; i >= 0; i--) begin
         w(10); m_sda_low = 1'b0;
         w(10); m_scl = 1'b1;
         w(10); b[i] = sda_bus;
         w(10); m_scl = 1'b0;
      end
      w(10); m_sda_low = mack;
      w(10); m_scl = 1'b1;
      w(20); m_scl = 1'b0;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] d;
      bit         a;
      for (int i = 0; i < 4; i++) exp_r[i] = DEF[8*i +: 8];
      w(5);
      // R1: defaults and released line while and after reset
      chk_regs("R1");
      chk(sda_oe == 1'b0, "R1", {31'd0, sda_oe}, 32'd0);
      rst_n = 1'b1;
      w(10);
      chk_regs("R1");

      // R2: foreign addresses are refused and nothing after them is taken
      for (int i = 0; i < 18; i++) begin
         logic [6:0] a7;
         a7 = (i == 16) ? 7'b1101000 : (i == 17) ? 7'b0101001 : 7'(i * 8 + 3);
         i2c_start();
         wbc({a7, 1'b0}, 1'b0, "R2");
         wbc(8'h00, 1'b0, "R2");
         wbc(8'h01, 1'b0, "R2");
         wbc(8'hEE, 1'b0, "R2");
         i2c_stop();
         chk_regs("R2");
      end

      // R3: nonzero command codes refused, later bytes ignored
      for (int i = 0; i < 3; i++) begin
         i2c_start();
         wbc(8'hD2, 1'b1, "R2");
         wbc((i == 0) ? 8'h01 : (i == 1) ? 8'h80 : 8'hFF, 1'b0, "R3");
         wbc(8'h02, 1'b0, "R3");
         wbc(8'h33, 1'b0, "R3");
         i2c_stop();
         chk_regs("R3");
      end

      // R4: out-of-range counts refused
      for (int i = 0; i < 3; i++) begin
         i2c_start();
         wbc(8'hD2, 1'b1, "R2");
         wbc(8'h00, 1'b1, "R3");
         wbc((i == 0) ? 8'h00 : (i == 1) ? 8'h05 : 8'hFF, 1'b0, "R4");
         wbc(8'h44, 1'b0, "R4");
         i2c_stop();
         chk_regs("R4");
      end

      // R5/R6: sweep counts and data patterns; one extra byte must be refused
      for (int c = 1; c <= 4; c++) begin
         for (int k = 0; k < 4; k++) begin
            i2c_start();
            wbc(8'hD2, 1'b1, "R2");
            wbc(8'h00, 1'b1, "R3");
            wbc(8'(c), 1'b1, "R4");
            for (int i = 0; i < c; i++) begin
               d = 8'((c * 37 + k * 91 + i * 53 + 7) & 255);
               wbc(d, 1'b1, "R5");
               exp_r[i] = d;
            end
            wbc(8'h5C, 1'b0, "R6");
            i2c_stop();
            chk_regs("R5");
            chk(sda_oe == 1'b0, "R8", {31'd0, sda_oe}, 32'd0);
         end
      end

      // R10: short SCL pulse inside a data byte adds no bit
      i2c_start();
      wbc(8'hD2, 1'b1, "R2");
      wbc(8'h00, 1'b1, "R3");
      wbc(8'h01, 1'b1, "R4");
      wr_byte(8'h96, 1'b1, a);
      chk(a == 1'b1, "R10", {31'd0, a}, 32'd1);
      exp_r[0] = 8'h96;
      i2c_stop();
      chk_regs("R10");

      // R8: bytes after STOP without START are ignored
      wbc(8'hD2, 1'b0, "R8");
      wbc(8'h00, 1'b0, "R8");
      wbc(8'h01, 1'b0, "R8");
      wbc(8'h11, 1'b0, "R8");
      i2c_stop();
      chk_regs("R8");

      // R7: repeated START after a partial write goes straight to a read
      i2c_start();
      wbc(8'hD2, 1'b1, "R2");
      wbc(8'h00, 1'b1, "R3");
      wbc(8'h04, 1'b1, "R4");
      wbc(8'h3C, 1'b1, "R5");
      exp_r[0] = 8'h3C;
      i2c_start();
      wbc(8'hD3, 1'b1, "R7");
      rd_byte(1'b1, d);
      chk(d == exp_r[0], "R7", {24'd0, d}, {24'd0, exp_r[0]});
      rd_byte(1'b0, d);
      chk(d == exp_r[1], "R7", {24'd0, d}, {24'd0, exp_r[1]});
      i2c_stop();
      chk_regs("R7");

      // R9: read back with wrap, ended by host NACK
      i2c_start();
      wbc(8'hD3, 1'b1, "R9");
      for (int i = 0; i < 6; i++) begin
         rd_byte(i < 5, d);
         chk(d == exp_r[i % 4], "R9", {24'd0, d}, {24'd0, exp_r[i % 4]});
      end
      w(10);
      chk(sda_oe == 1'b0, "R9", {31'd0, sda_oe}, 32'd0);
      i2c_stop();
      chk(sda_oe == 1'b0, "R8", {31'd0, sda_oe}, 32'd0);
      chk_regs("R9");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule